// File: doc/BRIEF.md
# Atomic Byte Bit-Set Unit

This unit carries out one indivisible read-modify-write that forces a single bit of a memory byte to one. A 32-bit instruction word and the value of its base register arrive together with a start pulse. The unit checks that the word encodes the bit-set operation. It adds the sign-extended 12-bit displacement to the base value to form the effective address. It then fetches the word that holds the target byte over a word-wide memory port. The byte lane is chosen from the low address bits and an endianness input. The unit ORs in the chosen bit and writes back only that byte, under a one-hot byte strobe.

For the whole sequence the unit holds the interrupt-enable flag it presents at zero and asserts a bus lock. When the sequence ends it puts back the enable value it saved when it accepted the operation. Faults reported by the memory side are turned into store-type cause codes. A read fault suppresses the write. An operation flagged as issued from a branch delay slot is refused: the unit raises an illegal-use flag and makes no memory access.

Top module: `bitset_rmw_unit`

## Requirements
- R1: A start is accepted only while the unit is idle and the instruction has bits [31:26]=000001, bits [20:16]=00111 and bit 15 = 1. Any other word is ignored: no memory request and no done pulse. Bits [25:21] appear unchanged on `base_idx_o`, bits [14:12] give the bit index and bits [11:0] give the displacement.
- R2: The effective address is `base_val_i` plus bits [11:0] sign-extended to the address width. Both the read and the write use that address with its two low bits cleared.
- R3: The byte lane is the effective address bits [1:0] XOR `{2{big_endian_i}}`. Lane n occupies data bits 8n+7 down to 8n.
- R4: The write carries the fetched byte ORed with (1 << bit index) on its own lane, with `mem_be_o` equal to (1 << lane). The other three bytes of the memory word stay unchanged.
- R5: `ie_o` follows `ie_i` while idle and is 0 in every cycle of the read and write phases. In the done cycle it shows the `ie_i` value captured at acceptance.
- R6: `mem_lock_o` is 1 from the read request cycle through the cycle that sees the write acknowledge, and 0 while idle and in the done cycle. Every request is made under the lock.
- R7: `done_o` is a one-cycle pulse, exactly one per accepted operation. Starts that arrive while an operation is in progress are ignored.
- R8: An error response to the read means no write is issued. The lock is released, and `exc_valid_o` is raised together with `done_o`.
- R9: The cause code on `exc_code_o` is 3 when `mem_err_kind_i` = 0 (translation miss) and 5 when it is 1 (address error). This applies to faults on either the read or the write, and a faulted write leaves memory unchanged.
- R10: With `in_delay_slot_i` = 1 at acceptance, `illegal_o` is raised with `done_o`. No request is made, the lock is never asserted and memory is untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to execute `instr_i` |
| instr_i | input | 32 | Instruction word |
| base_val_i | input | 32 | Value of the addressed base register |
| base_idx_o | output | 5 | Base register index taken from the instruction |
| in_delay_slot_i | input | 1 | Instruction sits in a branch delay slot |
| big_endian_i | input | 1 | Big-endian byte ordering when 1 |
| ie_i | input | 1 | Current interrupt-enable value |
| ie_o | output | 1 | Interrupt-enable value as seen by the core |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte strobe for writes |
| mem_lock_o | output | 1 | Bus lock |
| mem_rdata_i | input | 32 | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_wack_i | input | 1 | Write acknowledge |
| mem_err_i | input | 1 | Error response, replaces rvalid or wack |
| mem_err_kind_i | input | 1 | 0 translation miss, 1 address error |
| done_o | output | 1 | Operation finished (one cycle) |
| exc_valid_o | output | 1 | A fault ended the operation |
| exc_code_o | output | 5 | Store-type cause code |
| illegal_o | output | 1 | Refused delay-slot use |

## Verification
The bench builds the unit with its default 32-bit address and 32-bit data widths. This gives four byte lanes, so every pairing of lane, bit index and endianness can be reached and is covered exhaustively before the random phase. The memory responder varies its latency from one to three cycles. It injects faults of both kinds on either the read or the write, so the skipped-write path and the faulted-write path both finish against the same reference memory.

// File: rtl/bitset_pkg.sv
// Package: shared constants and types of the atomic bit-set unit.
// Assumes the 32-bit instruction layout and store-type cause numbering.
package bitset_pkg;

    localparam logic [5:0] MAJOR_OPC   = 6'b000001;
    localparam logic [4:0] SUB_OPC     = 5'b00111;
    localparam logic [4:0] CAUSE_MISS  = 5'd3;
    localparam logic [4:0] CAUSE_ADDR  = 5'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT_RD,
        ST_WRITE,
        ST_WAIT_WR,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/bitset_decode.sv
// Module: bitset_decode
// Recognises the bit-set instruction and forms the effective address.
// Assumes a fixed 32-bit instruction word; purely combinational.
module bitset_decode
    import bitset_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [31:0]       instr_i,
    input  logic [ADDR_W-1:0] base_val_i,
    output logic              hit_o,
    output logic [4:0]        base_idx_o,
    output logic [2:0]        bit_idx_o,
    output logic [ADDR_W-1:0] ea_o
);

    localparam int OFF_W = 12;

    logic [OFF_W-1:0]  disp;
    logic [ADDR_W-1:0] disp_sx;

    // Field split and opcode match.
    always_comb begin
        hit_o      = (instr_i[31:26] == MAJOR_OPC) &&
                     (instr_i[20:16] == SUB_OPC) &&
                     instr_i[15];
        base_idx_o = instr_i[25:21];
        bit_idx_o  = instr_i[14:12];
        disp       = instr_i[OFF_W-1:0];
    end

    // Sign extension and address add.
    always_comb begin
        disp_sx = {{(ADDR_W-OFF_W){disp[OFF_W-1]}}, disp};
        ea_o    = base_val_i + disp_sx;
    end

endmodule

// File: rtl/bitset_lane.sv
// Module: bitset_lane
// Picks the byte lane by endianness, sets the bit and builds the
// write data and one-hot strobe. Assumes byte-wide lanes.
module bitset_lane #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANE_W-1:0] ea_low_i,
    input  logic              big_endian_i,
    input  logic [2:0]        bit_idx_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [LANE_W-1:0] lane_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [LANES-1:0]  be_o
);

    logic [7:0] old_byte;
    logic [7:0] new_byte;

    // Lane selection and bit insertion.
    always_comb begin
        lane_o   = ea_low_i ^ {LANE_W{big_endian_i}};
        old_byte = rdata_i[int'(lane_o)*8 +: 8];
        new_byte = old_byte | (8'd1 << bit_idx_i);
    end

    // One slice of data and strobe per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            be_o[g]          = (lane_o == LANE_W'(g));
            wdata_o[g*8 +: 8] = be_o[g] ? new_byte : 8'h00;
        end
    end

endmodule

// File: rtl/bitset_seq.sv
// Module: bitset_seq
// Sequencer: read, wait, write, wait, done. Owns the lock, the
// interrupt-enable masking and fault capture. Assumes responses come
// at least one cycle after the request and only one is outstanding.
module bitset_seq
    import bitset_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_hit_i,
    input  logic       slot_i,
    input  logic       ie_i,
    input  logic       rvalid_i,
    input  logic       wack_i,
    input  logic       err_i,
    input  logic       err_kind_i,
    output seq_state_t state_o,
    output logic       accept_o,
    output logic       cap_rdata_o,
    output logic       ie_o,
    output logic       lock_o,
    output logic       req_o,
    output logic       we_o,
    output logic       done_o,
    output logic       exc_valid_o,
    output logic [4:0] exc_code_o,
    output logic       illegal_o
);

    seq_state_t state_q, state_d;
    logic       ie_save_q;
    logic       err_seen_q;
    logic [4:0] code_q;
    logic       illegal_q;
    logic       in_wait;

    // Acceptance and wait-state decode.
    always_comb begin
        accept_o    = (state_q == ST_IDLE) && start_hit_i;
        in_wait     = (state_q == ST_WAIT_RD) || (state_q == ST_WAIT_WR);
        cap_rdata_o = (state_q == ST_WAIT_RD) && rvalid_i && !err_i;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept_o) state_d = slot_i ? ST_DONE : ST_READ;
            ST_READ:    state_d = ST_WAIT_RD;
            ST_WAIT_RD: if (err_i) state_d = ST_DONE;
                        else if (rvalid_i) state_d = ST_WRITE;
            ST_WRITE:   state_d = ST_WAIT_WR;
            ST_WAIT_WR: if (err_i || wack_i) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Saved enable, delay-slot flag and fault capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_save_q  <= 1'b0;
            err_seen_q <= 1'b0;
            code_q     <= '0;
            illegal_q  <= 1'b0;
        end else if (accept_o) begin
            ie_save_q  <= ie_i;
            err_seen_q <= 1'b0;
            code_q     <= '0;
            illegal_q  <= slot_i;
        end else if (in_wait && err_i) begin
            err_seen_q <= 1'b1;
            code_q     <= err_kind_i ? CAUSE_ADDR : CAUSE_MISS;
        end
    end

    // Output decode from state.
    always_comb begin
        state_o     = state_q;
        req_o       = (state_q == ST_READ) || (state_q == ST_WRITE);
        we_o        = (state_q == ST_WRITE);
        lock_o      = (state_q != ST_IDLE) && (state_q != ST_DONE);
        done_o      = (state_q == ST_DONE);
        exc_valid_o = done_o && err_seen_q;
        exc_code_o  = exc_valid_o ? code_q : 5'd0;
        illegal_o   = done_o && illegal_q;
        if (state_q == ST_IDLE)      ie_o = ie_i;
        else if (state_q == ST_DONE) ie_o = ie_save_q;
        else                         ie_o = 1'b0;
    end

    // R7: done lasts a single cycle.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: the lock only drops into the done cycle.
    p_lock_drop_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> done_o);

    // R8: no write is issued after a read fault.
    p_no_write_after_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> !err_seen_q);

endmodule

// File: rtl/bitset_rmw_unit.sv
// Module: bitset_rmw_unit (top)
// Atomic byte bit-set: decode, locked read-modify-write of one byte,
// interrupt-enable masking and store-type fault reporting.
// Assumes a word-wide memory port with one outstanding request.
module bitset_rmw_unit
    import bitset_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       instr_i,
    input  logic [ADDR_W-1:0] base_val_i,
    output logic [4:0]        base_idx_o,
    input  logic              in_delay_slot_i,
    input  logic              big_endian_i,
    input  logic              ie_i,
    output logic              ie_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [DATA_W/8-1:0] mem_be_o,
    output logic              mem_lock_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    input  logic              mem_wack_i,
    input  logic              mem_err_i,
    input  logic              mem_err_kind_i,
    output logic              done_o,
    output logic              exc_valid_o,
    output logic [4:0]        exc_code_o,
    output logic              illegal_o
);

    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic              dec_hit;
    logic [2:0]        dec_bit;
    logic [ADDR_W-1:0] dec_ea;
    seq_state_t        state;
    logic              accept;
    logic              cap_rdata;
    logic [ADDR_W-1:0] op_ea_q;
    logic [2:0]        op_bit_q;
    logic              op_big_q;
    logic [DATA_W-1:0] rdata_q;
    logic [LANE_W-1:0] lane;

    bitset_decode #(.ADDR_W(ADDR_W)) u_decode (
        .instr_i    (instr_i),
        .base_val_i (base_val_i),
        .hit_o      (dec_hit),
        .base_idx_o (base_idx_o),
        .bit_idx_o  (dec_bit),
        .ea_o       (dec_ea)
    );

    bitset_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_hit_i (start_i && dec_hit),
        .slot_i      (in_delay_slot_i),
        .ie_i        (ie_i),
        .rvalid_i    (mem_rvalid_i),
        .wack_i      (mem_wack_i),
        .err_i       (mem_err_i),
        .err_kind_i  (mem_err_kind_i),
        .state_o     (state),
        .accept_o    (accept),
        .cap_rdata_o (cap_rdata),
        .ie_o        (ie_o),
        .lock_o      (mem_lock_o),
        .req_o       (mem_req_o),
        .we_o        (mem_we_o),
        .done_o      (done_o),
        .exc_valid_o (exc_valid_o),
        .exc_code_o  (exc_code_o),
        .illegal_o   (illegal_o)
    );

    // Operand capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_ea_q  <= '0;
            op_bit_q <= '0;
            op_big_q <= 1'b0;
        end else if (accept) begin
            op_ea_q  <= dec_ea;
            op_bit_q <= dec_bit;
            op_big_q <= big_endian_i;
        end
    end

    // Read data capture on a clean read response.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (cap_rdata) rdata_q <= mem_rdata_i;
    end

    bitset_lane #(.DATA_W(DATA_W)) u_lane (
        .ea_low_i     (op_ea_q[LANE_W-1:0]),
        .big_endian_i (op_big_q),
        .bit_idx_i    (op_bit_q),
        .rdata_i      (rdata_q),
        .lane_o       (lane),
        .wdata_o      (mem_wdata_o),
        .be_o         (mem_be_o)
    );

    // Word-aligned request address.
    always_comb mem_addr_o = {op_ea_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

    // R5: enable is masked whenever the bus is locked.
    p_ie_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock_o |-> !ie_o);

    // R6: every request is made under the lock.
    p_req_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_lock_o);

    // R4: a write strobes exactly one lane.
    p_be_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> ($countones(mem_be_o) == 1));

    // R4: the selected bit is set in the written data.
    p_bit_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> mem_wdata_o[int'(lane)*8 + int'(op_bit_q)]);

    // R10: a refused operation never held the bus.
    p_illegal_no_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $past(!mem_lock_o));

    // R1: a request only follows an accepted start.
    p_req_needs_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |-> $past(accept));

endmodule

// File: tb/bitset_rmw_unit_tb.sv
`timescale 1ns/1ps
module bitset_rmw_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] base_val_i = '0;
    logic [4:0]  base_idx_o;
    logic        in_delay_slot_i = 1'b0;
    logic        big_endian_i = 1'b0;
    logic        ie_i = 1'b0;
    logic        ie_o;
    logic        mem_req_o, mem_we_o, mem_lock_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [3:0]  mem_be_o;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_rvalid_i = 1'b0, mem_wack_i = 1'b0, mem_err_i = 1'b0;
    logic        mem_err_kind_i;
    logic        done_o, exc_valid_o, illegal_o;
    logic [4:0]  exc_code_o;

    always #2 clk = ~clk;

    bitset_rmw_unit u_dut (.*);

    int n_chk = 0, n_err = 0;
    int lat_cfg = 1, err_mode = 0;
    bit kind_cfg = 0;
    int n_req = 0, n_done = 0, n_ie_bad = 0, n_unlocked = 0;
    logic [31:0] rd_addr, wr_addr;
    logic [3:0]  wr_be;
    logic [31:0] mem [0:63];
    bit finished = 0;

    assign mem_err_kind_i = kind_cfg;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder and bus monitors.
    initial begin
        bit pend = 0, pend_we = 0;
        int cnt = 0;
        logic [31:0] p_addr, p_data;
        logic [3:0]  p_be;
        forever begin
            @(negedge clk);
            mem_rvalid_i = 0; mem_wack_i = 0; mem_err_i = 0;
            if (pend) begin
                cnt--;
                if (cnt == 0) begin
                    pend = 0;
                    if (pend_we ? (err_mode == 2) : (err_mode == 1)) mem_err_i = 1;
                    else if (pend_we) begin
                        for (int b = 0; b < 4; b++)
                            if (p_be[b]) mem[p_addr[7:2]][b*8 +: 8] = p_data[b*8 +: 8];
                        mem_wack_i = 1;
                    end else begin
                        mem_rdata_i  = mem[p_addr[7:2]];
                        mem_rvalid_i = 1;
                    end
                end
            end
            if (mem_req_o) begin
                n_req++; pend = 1; cnt = lat_cfg; pend_we = mem_we_o;
                p_addr = mem_addr_o; p_data = mem_wdata_o; p_be = mem_be_o;
                if (mem_we_o) begin wr_addr = mem_addr_o; wr_be = mem_be_o; end
                else rd_addr = mem_addr_o;
            end
            if (done_o) n_done++;
            if (mem_lock_o && ie_o) n_ie_bad++;
            if (mem_req_o && !mem_lock_o) n_unlocked++;
        end
    end

    function automatic logic [31:0] mk_instr(input logic [2:0] b, input logic [11:0] off,
                                             input logic [4:0] rix);
        return {6'b000001, rix, 5'b00111, 1'b1, b, off};
    endfunction

    function automatic logic [31:0] ea_of(input logic [31:0] base, input logic [11:0] off);
        return base + {{20{off[11]}}, off};
    endfunction

    // One operation with a full check against the reference model.
    task automatic run_case(input logic [2:0] b, input logic [11:0] off, input logic [31:0] base,
                            input bit bend, input bit ie, input int lat, input int emode,
                            input bit kind, input bit slot, input bit hold);
        logic [31:0] ea, old_w, exp_w;
        logic [1:0]  lane;
        logic [4:0]  rix;
        int r0, d0, t;
        bit got_exc, got_ill, got_ie;
        logic [4:0] got_code;
        ea = ea_of(base, off);
        lane = ea[1:0] ^ {2{bend}};
        old_w = mem[ea[7:2]];
        exp_w = old_w;
        exp_w[lane*8 + b] = 1'b1;
        rix = 5'($urandom);
        lat_cfg = lat; err_mode = emode; kind_cfg = kind;
        r0 = n_req; d0 = n_done;
        @(negedge clk);
        instr_i = mk_instr(b, off, rix); base_val_i = base; big_endian_i = bend;
        ie_i = ie; in_delay_slot_i = slot; start_i = 1;
        #0.1;
        check(base_idx_o == rix, "R1", "base index", 32'(base_idx_o), 32'(rix));
        t = 0;
        do begin
            @(negedge clk);
            if (!hold) start_i = 0;
            t++;
        end while (!done_o && t < 40);
        start_i = 0;
        check(t < 40, "R7", "done timeout", t, 40);
        got_exc = exc_valid_o; got_code = exc_code_o; got_ill = illegal_o; got_ie = ie_o;
        check(got_ie == ie, "R5", "restored enable", 32'(got_ie), 32'(ie));
        @(negedge clk);
        check(!done_o, "R7", "done width", 32'(done_o), 0);
        check(n_done - d0 == 1, "R7", "done count", n_done - d0, 1);
        if (slot) begin
            check(n_req == r0, "R10", "requests", n_req - r0, 0);
            check(got_ill, "R10", "illegal flag", 32'(got_ill), 1);
            check(mem[ea[7:2]] == old_w, "R10", "memory", mem[ea[7:2]], old_w);
        end else begin
            check(!got_ill, "R10", "illegal flag", 32'(got_ill), 0);
            check(rd_addr == {ea[31:2], 2'b00}, "R2", "read address", rd_addr, {ea[31:2], 2'b00});
            if (emode != 0) begin
                check(n_req - r0 == emode, "R8", "requests", n_req - r0, emode);
                check(got_exc, "R8", "exc valid", 32'(got_exc), 1);
                check(got_code == (kind ? 5'd5 : 5'd3), "R9", "cause code",
                      32'(got_code), kind ? 5 : 3);
                check(mem[ea[7:2]] == old_w, "R9", "memory kept", mem[ea[7:2]], old_w);
            end else begin
                check(n_req - r0 == 2, "R7", "requests", n_req - r0, 2);
                check(!got_exc, "R8", "exc valid", 32'(got_exc), 0);
                check(wr_addr == {ea[31:2], 2'b00}, "R2", "write address", wr_addr, {ea[31:2], 2'b00});
                check(wr_be == 4'(1 << lane), "R3", "byte strobe", 32'(wr_be), 32'(1 << lane));
                check(mem[ea[7:2]] == exp_w, "R4", "memory word", mem[ea[7:2]], exp_w);
            end
        end
    endtask

    // A start with a non-matching word must do nothing.
    task automatic run_ignored(input logic [31:0] w);
        int r0, d0;
        r0 = n_req; d0 = n_done;
        @(negedge clk);
        instr_i = w; in_delay_slot_i = 0; start_i = 1;
        @(negedge clk);
        start_i = 0;
        repeat (8) @(negedge clk);
        check(n_req == r0, "R1", "ignored word requests", n_req - r0, 0);
        check(n_done == d0, "R1", "ignored word done", n_done - d0, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = $urandom(32'h5eed1234) & 0;
        for (int i = 0; i < 64; i++) mem[i] = $urandom;
        ie_i = 1;
        repeat (3) @(negedge clk);
        check(!mem_lock_o && !mem_req_o && !done_o, "R6", "reset outputs",
              {29'd0, mem_lock_o, mem_req_o, done_o}, 0);
        check(ie_o == 1, "R5", "idle passthrough", 32'(ie_o), 1);
        rst_n = 1;
        @(negedge clk);
        ie_i = 0; #0.1;
        check(ie_o == 0, "R5", "idle passthrough low", 32'(ie_o), 0);

        // Every lane, bit and endianness.
        for (int e = 0; e < 2; e++)
            for (int ln = 0; ln < 4; ln++)
                for (int b = 0; b < 8; b++)
                    run_case(3'(b), 12'(ln + 4 * b), 32'h100, bit'(e), bit'(b & 1),
                             1 + (b % 3), 0, 0, 0, 0);

        // Negative displacement and carry across the upper address bits.
        run_case(3'd7, 12'hFFF, 32'h0000_0000, 0, 1, 2, 0, 0, 0, 0);
        run_case(3'd0, 12'h800, 32'h0000_0803, 1, 1, 1, 0, 0, 0, 0);

        // Faults of each kind on each access.
        run_case(3'd2, 12'h014, 32'h40, 0, 1, 2, 1, 0, 0, 0);
        run_case(3'd5, 12'h023, 32'h40, 1, 1, 3, 1, 1, 0, 0);
        run_case(3'd6, 12'h031, 32'h40, 0, 1, 1, 2, 0, 0, 0);
        run_case(3'd1, 12'h002, 32'h40, 1, 0, 2, 2, 1, 0, 0);

        // Delay-slot refusal and start held high during an operation.
        run_case(3'd3, 12'h010, 32'h80, 0, 1, 1, 0, 0, 1, 0);
        run_case(3'd4, 12'h011, 32'h80, 1, 1, 3, 0, 0, 0, 1);

        // Non-matching instruction words.
        run_ignored({6'b000010, 5'd1, 5'b00111, 1'b1, 15'd5});
        run_ignored({6'b000001, 5'd1, 5'b00110, 1'b1, 15'd5});
        run_ignored({6'b000001, 5'd1, 5'b00111, 1'b0, 15'd5});

        // Random mix.
        for (int i = 0; i < 220; i++) begin
            int em;
            em = ($urandom % 10 == 0) ? 1 + ($urandom % 2) : 0;
            run_case(3'($urandom), 12'($urandom), $urandom, 1'($urandom), 1'($urandom),
                     1 + ($urandom % 3), em, 1'($urandom), ($urandom % 16 == 0),
                     ($urandom % 8 == 0));
        end

        check(n_ie_bad == 0, "R5", "enable high under lock", n_ie_bad, 0);
        check(n_unlocked == 0, "R6", "request without lock", n_unlocked, 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule